// File: doc/BRIEF.md
# SRAM test command sequencer

This block is a self-contained memory tester. A host on a 16-bit register port loads a short program into a command store. Each program entry is a 32-bit command word and a 32-bit data word. The host also sets a base data word, a base address and a set of mode bits, then starts a run. The engine steps through the entries from index 0 up to a programmed last index. For each entry it idles for the entry's wait count, then performs a single read or write with byte enables on an internal synchronous SRAM model. The model has one cycle of read latency and aliases addresses modulo its depth.

Data and address can each be scrambled by XOR with the base registers. Reads can be verified against the data word under the active byte enables. The first mismatch stops the run and latches the failing address and the read data. In loop mode the base address is incremented after every pass. The program is repeated until the pass with the all-ones base address has been executed. Every run that finishes, whether clean or failed, raises a one-cycle attention pulse. A run that is halted by the host raises no pulse.

Register offsets (5-bit `reg_addr`):
- 0x00 / 0x01: base data high / low.
- 0x04 / 0x05: base address high bits / low 16 bits.
- 0x08: last index.
- 0x09: entry pointer.
- 0x0a: program window.
- 0x0d: status and mode.
- 0x0e: go.
- 0x0f: halt.
- 0x10: error address bits 15:0.
- 0x11 / 0x12: error data high / low.

Reads of any other offset return 0.

Top module: `memtest_seq`

## Requirements
- R1: After reset, the status register (0x0d) reads 0x4000: bits 15:13 hold ADDR_W-16, which is 2 for the default width, and every other bit is 0. The error registers (0x10 to 0x12) and the pointer (0x09) read 0, and `attn` is low.
- R2: Each access to the program window (0x0a) reaches one 16-bit word at the pointer and then advances the pointer by one. Entry n occupies pointer values 4n to 4n+3, holding command high, command low, data high and data low in that order. A write to 0x09 sets the pointer, and a read of 0x09 returns it.
- R3: Command word fields are: bits 31:28 wait count, bit 24 write (1) or read (0), bits 23:20 byte enables (bit 20 enables data bits 7:0), and bits 17:0 address. A write to go (0x0e) executes entries 0 through the last index (0x08) in order, and status bit 0 (run) reads 1 until the run ends.
- R4: Timing is counted from the clock edge that accepts the go write to the edge after which `attn` is high. In that span, a write or unverified read entry takes 3+wait cycles, and a verified read that matches takes 4+wait cycles.
- R5: With status bit 6 set, the entry's data word is XORed with the base data, both for write data and for the expected value. With status bit 5 set, the command address is XORed with the base address.
- R6: With status bit 4 set, each read is compared with the expected value over the enabled bytes only. On the first mismatch, status bit 1 (fail) is set and the effective address goes to 0x10. The raw read data goes to 0x11 and 0x12. The run then ends and no later entry is executed.
- R7: When a run completes, `attn` pulses high for exactly one cycle and run drops. After a clean run the error registers read 0, and mode bits 9:4 read back as written.
- R8: With status bit 7 set, after the last entry the base address is incremented and the program repeats. The run ends after the pass with the all-ones base address, so the base address then reads all ones.
- R9: A write to halt (0x0f) ends a run at once, with no `attn` pulse and no further memory access. A write to 0x0d loads mode bits 9:4 and clears fail. Bits 9 and 8 are stored and read back only.
- R10: A write entry changes only the enabled bytes of the addressed SRAM word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register offset |
| reg_wr | input | 1 | Register write strobe, one access per cycle |
| reg_rd | input | 1 | Register read strobe (advances pointer on the program window) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| attn | output | 1 | One-cycle pulse when a run completes or fails |

## Verification
The bench goes after masked compares: a mismatch confined to a disabled byte must not fail. A design that compared full words would stop early and report the wrong address. It checks that a failure stops the program, using a write placed after the failing read that must leave memory unchanged. A design that kept running after the first mismatch would overwrite that word. The loop test starts three steps below the all-ones base address, so an off-by-one end condition shows up as a wrong pass count, a wrong cycle count or a wrapped base address. Exact cycle counts for random wait values expose miscounted idle cycles. A halt in the middle of a wait must produce no attention pulse and no write.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

    localparam int WAIT_W  = 4;
    localparam int WAIT_HI = 31;
    localparam int WAIT_LO = 28;
    localparam int WE_BIT  = 24;
    localparam int BE_HI   = 23;
    localparam int BE_LO   = 20;

    localparam logic [4:0] RA_BDATH = 5'h00;
    localparam logic [4:0] RA_BDATL = 5'h01;
    localparam logic [4:0] RA_BADRH = 5'h04;
    localparam logic [4:0] RA_BADRL = 5'h05;
    localparam logic [4:0] RA_LAST  = 5'h08;
    localparam logic [4:0] RA_PTR   = 5'h09;
    localparam logic [4:0] RA_PROG  = 5'h0a;
    localparam logic [4:0] RA_MODE  = 5'h0d;
    localparam logic [4:0] RA_GO    = 5'h0e;
    localparam logic [4:0] RA_HALT  = 5'h0f;
    localparam logic [4:0] RA_EADR  = 5'h10;
    localparam logic [4:0] RA_EDATH = 5'h11;
    localparam logic [4:0] RA_EDATL = 5'h12;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_LOAD = 3'd1,
        S_WAIT = 3'd2,
        S_ACC  = 3'd3,
        S_CHK  = 3'd4,
        S_ADV  = 3'd5
    } seq_state_e;

    // packed order matches status bits 9..4
    typedef struct packed {
        logic wswap;
        logic wloop;
        logic loop;
        logic xord;
        logic xora;
        logic veri;
    } mode_t;

    function automatic logic [31:0] be_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/memtest_store.sv
module memtest_store
    import memtest_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_wr,
    input  logic                      host_rd,
    input  logic                      ptr_wr,
    input  logic [15:0]               wdata,
    output logic [$clog2(DEPTH)+1:0]  ptr,
    output logic [15:0]               host_word,
    input  logic [$clog2(DEPTH)-1:0]  eng_idx,
    output logic [63:0]               eng_entry
);
    localparam int IW    = $clog2(DEPTH);
    localparam int PW    = IW + 2;
    localparam int WORDS = DEPTH * 4;

    logic [15:0]   mem [WORDS];
    logic [PW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (ptr_wr) begin
            ptr_d = wdata[PW-1:0];
        end else if (host_wr || host_rd) begin
            ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (host_wr) begin
            mem[ptr_q] <= wdata;
        end
    end

    assign ptr       = ptr_q;
    assign host_word = mem[ptr_q];

    generate
        for (genvar w = 0; w < 4; w++) begin : g_word
            assign eng_entry[63-16*w -: 16] = mem[{eng_idx, 2'(w)}];
        end
    endgenerate

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr || host_rd) && !ptr_wr) |=> (ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/memtest_sram.sv
module memtest_sram #(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [3:0]        be,
    input  logic [MEM_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int ROWS = 1 << MEM_AW;

    generate
        for (genvar b = 0; b < 4; b++) begin : g_lane
            logic [7:0] lane_mem [ROWS];
            logic [7:0] rbyte;

            always_ff @(posedge clk) begin
                if (en && we && be[b]) begin
                    lane_mem[addr] <= wdata[8*b +: 8];
                end
                if (en && !we) begin
                    rbyte <= lane_mem[addr];
                end
            end

            assign rdata[8*b +: 8] = rbyte;
        end
    endgenerate

endmodule

// File: rtl/memtest_engine.sv
module memtest_engine
    import memtest_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int IW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [IW-1:0]     cur_idx,
    input  logic [63:0]       cur_entry,
    output logic              mem_en,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       base_data,
    output logic [ADDR_W-1:0] base_addr,
    output logic [IW-1:0]     last_idx,
    output mode_t             mode,
    output logic              running,
    output logic              failed,
    output logic [ADDR_W-1:0] err_addr,
    output logic [31:0]       err_data,
    output logic              attn
);
    localparam int HW = ADDR_W - 16;

    typedef struct packed {
        seq_state_e        state;
        logic [IW-1:0]     idx;
        logic [WAIT_W-1:0] wcnt;
        logic [31:0]       bdat;
        logic [ADDR_W-1:0] badr;
        logic [IW-1:0]     last;
        mode_t             mode;
        logic              run;
        logic              fail;
        logic [ADDR_W-1:0] eadr;
        logic [31:0]       edat;
        logic              attn;
    } eng_t;

    eng_t q, d;

    logic [WAIT_W-1:0] cmd_wait;
    logic              cmd_we;
    logic [3:0]        cmd_be;
    logic [ADDR_W-1:0] eff_addr;
    logic [31:0]       eff_data;
    logic              mismatch;
    logic              unused_bits;

    assign cmd_wait    = cur_entry[32+WAIT_HI:32+WAIT_LO];
    assign cmd_we      = cur_entry[32+WE_BIT];
    assign cmd_be      = cur_entry[32+BE_HI:32+BE_LO];
    assign eff_addr    = cur_entry[32+ADDR_W-1:32] ^ (q.mode.xora ? q.badr : '0);
    assign eff_data    = cur_entry[31:0] ^ (q.mode.xord ? q.bdat : 32'h0);
    assign mismatch    = ((mem_rdata ^ eff_data) & be_mask(cmd_be)) != 32'h0;
    assign unused_bits = ^{cur_entry[32+WAIT_LO-1:32+WE_BIT+1],
                           cur_entry[32+BE_LO-1:32+ADDR_W]};

    always_comb begin
        d      = q;
        d.attn = 1'b0;

        case (q.state)
            S_IDLE: ;
            S_LOAD: begin
                d.wcnt  = cmd_wait;
                d.state = (cmd_wait == '0) ? S_ACC : S_WAIT;
            end
            S_WAIT: begin
                d.wcnt = q.wcnt - 1'b1;
                if (q.wcnt == 1) begin
                    d.state = S_ACC;
                end
            end
            S_ACC: begin
                d.state = (!cmd_we && q.mode.veri) ? S_CHK : S_ADV;
            end
            S_CHK: begin
                if (mismatch) begin
                    d.fail  = 1'b1;
                    d.eadr  = eff_addr;
                    d.edat  = mem_rdata;
                    d.run   = 1'b0;
                    d.attn  = 1'b1;
                    d.state = S_IDLE;
                end else begin
                    d.state = S_ADV;
                end
            end
            S_ADV: begin
                if (q.idx == q.last) begin
                    if (q.mode.loop && (q.badr != '1)) begin
                        d.badr  = q.badr + 1'b1;
                        d.idx   = '0;
                        d.state = S_LOAD;
                    end else begin
                        d.run   = 1'b0;
                        d.attn  = 1'b1;
                        d.state = S_IDLE;
                    end
                end else begin
                    d.idx   = q.idx + 1'b1;
                    d.state = S_LOAD;
                end
            end
            default: d.state = S_IDLE;
        endcase

        if (reg_wr) begin
            case (reg_addr)
                RA_BDATH: d.bdat[31:16] = reg_wdata;
                RA_BDATL: d.bdat[15:0]  = reg_wdata;
                RA_BADRH: d.badr[ADDR_W-1:16] = reg_wdata[HW-1:0];
                RA_BADRL: d.badr[15:0]  = reg_wdata;
                RA_LAST:  d.last        = reg_wdata[IW-1:0];
                RA_MODE: begin
                    d.mode = mode_t'(reg_wdata[9:4]);
                    d.fail = 1'b0;
                end
                RA_GO: begin
                    d.state = S_LOAD;
                    d.idx   = '0;
                    d.run   = 1'b1;
                    d.fail  = 1'b0;
                    d.eadr  = '0;
                    d.edat  = '0;
                end
                RA_HALT: begin
                    d.state = S_IDLE;
                    d.run   = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cur_idx   = q.idx;
    assign mem_en    = (q.state == S_ACC);
    assign mem_we    = cmd_we;
    assign mem_be    = cmd_be;
    assign mem_addr  = eff_addr;
    assign mem_wdata = eff_data;
    assign base_data = q.bdat;
    assign base_addr = q.badr;
    assign last_idx  = q.last;
    assign mode      = q.mode;
    assign running   = q.run;
    assign failed    = q.fail;
    assign err_addr  = q.eadr;
    assign err_data  = q.edat;
    assign attn      = q.attn;

    // R7
    attn_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.attn |-> !q.run);

    // R3
    access_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> q.run);

    // R6
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fail && !(reg_wr && (reg_addr == RA_MODE || reg_addr == RA_GO))) |=> q.fail);

    // R4
    wait_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_WAIT) |-> (q.wcnt != '0));

    // R8
    loop_base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !reg_wr) |=> ((q.badr == $past(q.badr)) || (q.badr == $past(q.badr) + 1'b1)));

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
    import memtest_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DEPTH  = 64,
    parameter int MEM_AW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        attn
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 2;
    localparam logic [2:0] AWF = 3'(ADDR_W - 16);

    logic [PW-1:0]     ptr;
    logic [15:0]       prog_word;
    logic [IW-1:0]     cur_idx;
    logic [63:0]       cur_entry;
    logic              mem_en, mem_we;
    logic [3:0]        mem_be;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata, mem_rdata;
    logic [31:0]       base_data;
    logic [ADDR_W-1:0] base_addr;
    logic [IW-1:0]     last_idx;
    mode_t             mode;
    logic              running, failed;
    logic [ADDR_W-1:0] err_addr;
    logic [31:0]       err_data;
    logic              unused_top;

    assign unused_top = ^{mem_addr[ADDR_W-1:MEM_AW], err_addr[ADDR_W-1:16], last_idx};

    memtest_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (reg_wr && (reg_addr == RA_PROG)),
        .host_rd   (reg_rd && (reg_addr == RA_PROG)),
        .ptr_wr    (reg_wr && (reg_addr == RA_PTR)),
        .wdata     (reg_wdata),
        .ptr       (ptr),
        .host_word (prog_word),
        .eng_idx   (cur_idx),
        .eng_entry (cur_entry)
    );

    memtest_engine #(.ADDR_W(ADDR_W), .IW(IW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cur_idx   (cur_idx),
        .cur_entry (cur_entry),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_be    (mem_be),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .base_data (base_data),
        .base_addr (base_addr),
        .last_idx  (last_idx),
        .mode      (mode),
        .running   (running),
        .failed    (failed),
        .err_addr  (err_addr),
        .err_data  (err_data),
        .attn      (attn)
    );

    memtest_sram #(.MEM_AW(MEM_AW)) u_sram (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .be    (mem_be),
        .addr  (mem_addr[MEM_AW-1:0]),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        case (reg_addr)
            RA_BDATH: reg_rdata = base_data[31:16];
            RA_BDATL: reg_rdata = base_data[15:0];
            RA_BADRH: reg_rdata = 16'(base_addr[ADDR_W-1:16]);
            RA_BADRL: reg_rdata = base_addr[15:0];
            RA_LAST:  reg_rdata = 16'(last_idx);
            RA_PTR:   reg_rdata = 16'(ptr);
            RA_PROG:  reg_rdata = prog_word;
            RA_MODE:  reg_rdata = {AWF, 3'b000, mode, 2'b00, failed, running};
            RA_EADR:  reg_rdata = err_addr[15:0];
            RA_EDATH: reg_rdata = err_data[31:16];
            RA_EDATL: reg_rdata = err_data[15:0];
            default:  reg_rdata = 16'h0000;
        endcase
    end

endmodule

// File: tb/memtest_seq_bench.sv
module memtest_seq_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_BDH = 5'h00, A_BDL = 5'h01, A_BAH = 5'h04, A_BAL = 5'h05;
    localparam logic [4:0] A_LST = 5'h08, A_PTR = 5'h09, A_PRG = 5'h0a, A_STS = 5'h0d;
    localparam logic [4:0] A_GO = 5'h0e, A_HLT = 5'h0f, A_EAD = 5'h10, A_EDH = 5'h11, A_EDL = 5'h12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        attn;

    int nchk = 0;
    int nfail = 0;
    int cycles = 0;

    logic [31:0] pc [64];
    logic [31:0] pv [64];
    logic [31:0] bmem [256];

    memtest_seq u_memtest_seq (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .attn(attn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    function automatic logic [31:0] mkcmd(input int w, input bit we, input logic [3:0] be, input logic [17:0] a);
        return {4'(w), 3'b000, we, be, 2'b00, a};
    endfunction

    function automatic logic [31:0] bmask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic load(input int n);
        wr(A_PTR, 16'h0000);
        for (int i = 0; i < n; i++) begin
            wr(A_PRG, pc[i][31:16]); wr(A_PRG, pc[i][15:0]);
            wr(A_PRG, pv[i][31:16]); wr(A_PRG, pv[i][15:0]);
        end
        wr(A_LST, 16'(n - 1));
    endtask

    task automatic go(output int cyc);
        wr(A_GO, 16'h0000);
        cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            if (attn || cyc > 4000) break;
        end
    endtask

    // model of one write entry
    task automatic model_wr(input logic [31:0] c, input logic [31:0] v, input bit xd, input bit xa,
                            input logic [31:0] bd, input logic [17:0] ba);
        logic [7:0]  ea;
        logic [31:0] dv, m;
        ea = 8'(c[17:0] ^ (xa ? ba : 18'h0));
        dv = v ^ (xd ? bd : 32'h0);
        m  = bmask(c[23:20]);
        bmem[ea] = (bmem[ea] & ~m) | (dv & m);
    endtask

    // read one word through a forced verify failure
    task automatic peek(input int a, input string tag);
        int cyc;
        logic [15:0] s, h, l;
        pc[0] = mkcmd(0, 1'b0, 4'hF, 18'(a)); pv[0] = bmem[a] ^ 32'h1;
        load(1);
        wr(A_STS, 16'h0010);
        go(cyc);
        rd(A_STS, s); rd(A_EDH, h); rd(A_EDL, l);
        chk(s[1] == 1'b1, {tag, " fail flag"}, 32'(s), 32'h4012);
        chk({h, l} == bmem[a], {tag, " word"}, {h, l}, bmem[a]);
    endtask

    initial begin
        logic [15:0] r, r2;
        int cyc, exp_cyc, n;
        logic [31:0] bd;
        logic [17:0] ba;
        bit xd, xa;
        void'($urandom(32'd1207));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(A_STS, r); chk(r == 16'h4000, "R1 status", 32'(r), 32'h4000);
        rd(A_EAD, r); chk(r == 16'h0, "R1 eadr", 32'(r), 0);
        rd(A_EDH, r); rd(A_EDL, r2); chk({r, r2} == 32'h0, "R1 edat", {r, r2}, 0);
        rd(A_PTR, r); chk(r == 16'h0, "R1 ptr", 32'(r), 0);
        chk(attn == 1'b0, "R1 attn", 32'(attn), 0);

        // R4 R10 fill all 256 words, 64 full-word writes per run
        wr(A_STS, 16'h0000);
        for (int blk = 0; blk < 4; blk++) begin
            for (int i = 0; i < 64; i++) begin
                pc[i] = mkcmd(0, 1'b1, 4'hF, 18'(blk*64 + i));
                pv[i] = 32'hA5A5A5A5 ^ (32'(blk*64 + i) * 32'h01010101);
                model_wr(pc[i], pv[i], 1'b0, 1'b0, 0, 0);
            end
            load(64);
            go(cyc);
            chk(cyc == 192, "R4 fill timing", 32'(cyc), 192);
        end
        peek(0, "R3 fill"); peek(255, "R3 fill");

        // R2 program window and pointer
        pc[0] = mkcmd(3, 1'b1, 4'h5, 18'h2ABCD); pv[0] = 32'h01234567;
        pc[1] = mkcmd(9, 1'b0, 4'hA, 18'h10001); pv[1] = 32'h89ABCDEF;
        load(2);
        rd(A_PTR, r); chk(r == 16'd8, "R2 ptr after load", 32'(r), 8);
        wr(A_PTR, 16'd4);
        rd(A_PRG, r); chk(r == pc[1][31:16], "R2 cmd hi", 32'(r), 32'(pc[1][31:16]));
        rd(A_PRG, r); chk(r == pc[1][15:0], "R2 cmd lo", 32'(r), 32'(pc[1][15:0]));
        rd(A_PRG, r); chk(r == pv[1][31:16], "R2 val hi", 32'(r), 32'(pv[1][31:16]));
        rd(A_PRG, r); chk(r == pv[1][15:0], "R2 val lo", 32'(r), 32'(pv[1][15:0]));
        rd(A_PTR, r); chk(r == 16'd8, "R2 ptr after reads", 32'(r), 8);

        // R10 partial byte write
        pc[0] = mkcmd(0, 1'b1, 4'h5, 18'h00033); pv[0] = 32'hDEADBEEF;
        model_wr(pc[0], pv[0], 1'b0, 1'b0, 0, 0);
        load(1); wr(A_STS, 16'h0000); go(cyc);
        peek(8'h33, "R10 byte lanes");

        // R5 R4 R7 constrained random rounds
        for (int rnd = 0; rnd < 4; rnd++) begin
            logic [3:0] be;
            logic [7:0] eas [8];
            n  = 4 + int'($urandom_range(4));
            bd = $urandom;
            ba = 18'($urandom);
            xd = 1'($urandom); xa = 1'($urandom);
            wr(A_BDH, bd[31:16]); wr(A_BDL, bd[15:0]);
            wr(A_BAH, 16'(ba[17:16])); wr(A_BAL, ba[15:0]);
            exp_cyc = 0;
            for (int i = 0; i < n; i++) begin
                be = 4'($urandom_range(14) + 1);
                pc[i] = mkcmd(int'($urandom_range(15)), 1'b1, be, 18'($urandom));
                pv[i] = $urandom;
                eas[i] = 8'(pc[i][17:0] ^ (xa ? ba : 18'h0));
                exp_cyc += 3 + int'(pc[i][31:28]);
                model_wr(pc[i], pv[i], xd, xa, bd, ba);
            end
            load(n);
            wr(A_STS, {6'b0, 4'b0000, 1'b0, xd, xa, 1'b0, 4'b0});
            go(cyc);
            chk(cyc == exp_cyc, "R4 random write timing", 32'(cyc), 32'(exp_cyc));
            for (int i = 0; i < n; i++) peek(int'(eas[i]), "R5 scrambled write");

            // verified reads, all matching, with scrambling on and stored mode bits
            exp_cyc = 0;
            for (int i = 0; i < n; i++) begin
                pc[i] = mkcmd(int'($urandom_range(15)), 1'b0, 4'($urandom_range(14) + 1),
                              18'(eas[i]) ^ ba);
                pv[i] = bmem[eas[i]] ^ bd;
                exp_cyc += 4 + int'(pc[i][31:28]);
            end
            load(n);
            wr(A_STS, 16'h0370);
            go(cyc);
            chk(cyc == exp_cyc, "R4 verified read timing", 32'(cyc), 32'(exp_cyc));
            rd(A_STS, r); chk(r == 16'h4370, "R7 clean status", 32'(r), 32'h4370);
            rd(A_EAD, r); chk(r == 16'h0, "R7 clean eadr", 32'(r), 0);
            rd(A_EDH, r); rd(A_EDL, r2); chk({r, r2} == 32'h0, "R7 clean edat", {r, r2}, 0);
        end

        // R6 masked compare, first failure stops the run
        wr(A_BDH, 16'h0); wr(A_BDL, 16'h0); wr(A_BAH, 16'h0); wr(A_BAL, 16'h0);
        pc[0] = mkcmd(0, 1'b0, 4'h1, 18'h33); pv[0] = bmem[8'h33] ^ 32'hFFFFFF00;
        pc[1] = mkcmd(0, 1'b0, 4'h2, 18'h33); pv[1] = bmem[8'h33] ^ 32'h00000100;
        pc[2] = mkcmd(0, 1'b1, 4'hF, 18'h44); pv[2] = 32'h12345678;
        load(3);
        wr(A_STS, 16'h0010);
        go(cyc);
        chk(cyc == 7, "R6 fail timing", 32'(cyc), 7);
        rd(A_STS, r); chk(r == 16'h4012, "R6 status", 32'(r), 32'h4012);
        rd(A_EAD, r); chk(r == 16'h0033, "R6 eadr", 32'(r), 32'h33);
        rd(A_EDH, r); rd(A_EDL, r2);
        chk({r, r2} == bmem[8'h33], "R6 edat", {r, r2}, bmem[8'h33]);
        peek(8'h44, "R6 later entry skipped");
        wr(A_STS, 16'h0010);
        rd(A_STS, r); chk(r == 16'h4010, "R9 mode write clears fail", 32'(r), 32'h4010);

        // R8 loop over the top of the base-address space
        wr(A_BAH, 16'h0003); wr(A_BAL, 16'hFFFC);
        pc[0] = mkcmd(2, 1'b1, 4'hF, 18'h0); pv[0] = 32'h5A5A0F0F;
        for (int b = 8'hFC; b <= 8'hFF; b++) bmem[b] = 32'h5A5A0F0F;
        load(1);
        wr(A_STS, 16'h00A0);
        go(cyc);
        chk(cyc == 20, "R8 loop timing", 32'(cyc), 20);
        rd(A_BAH, r); rd(A_BAL, r2);
        chk({r, r2} == 32'h0003FFFF, "R8 final base", {r, r2}, 32'h0003FFFF);
        peek(8'hFC, "R8 first pass"); peek(8'hFF, "R8 last pass");

        // R9 halt during wait: no attention, no write
        pc[0] = mkcmd(15, 1'b1, 4'hF, 18'h10); pv[0] = ~bmem[8'h10];
        pc[1] = mkcmd(15, 1'b1, 4'hF, 18'h11); pv[1] = ~bmem[8'h11];
        load(2);
        wr(A_STS, 16'h0000);
        wr(A_GO, 16'h0);
        rd(A_STS, r); chk(r[0] == 1'b1, "R3 run during wait", 32'(r), 32'h4001);
        wr(A_HLT, 16'h0);
        rd(A_STS, r); chk(r == 16'h4000, "R9 halted status", 32'(r), 32'h4000);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #1;
            if (attn) n++;
        end
        chk(n == 0, "R9 no attn after halt", 32'(n), 0);
        peek(8'h10, "R9 no write after halt");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule